// File: doc/BRIEF.md
# Private peripheral bus decoder

This block sits in front of the private peripheral space of a processor subsystem, a 1 MB window starting at 0xE000_0000. Each request carries an address, a write flag, an access size, wdata and two attributes: secure and user (unprivileged). The block picks at most one target in the same cycle and forwards the page offset, the attributes and the write data to it. The targets are the system-register and interrupt-controller block, a timer register block with one instance for each security state, and an optional error-record block. Space that no target claims is answered locally.

Where regions overlap, a fixed priority settles the winner. The timer window beats the system-register block, and both beat the local default responder. When the security option is built in, a second 4 KB page works as a non-secure view of the system-register and timer space. A secure request there reaches the real target with its secure attribute cleared. A non-secure request there gets the same local answer as unclaimed space. The response from the chosen target, or the local answer, is registered. It comes back one cycle after the request, together with its error flag.

Top module: `ppb_router`

## Requirements
- R1: A request selects a target and gives a response only when req_valid is 1 and req_addr[31:20] is 0xE00. Otherwise all selects stay 0 and rsp_valid is 0 in the next cycle.
- R2: An access to page 0xE000_E000..0xE000_EFFF outside the timer range asserts sel_sys. fwd_off is req_addr[11:0], and fwd_secure equals req_secure.
- R3: Page offsets 0x010..0x0EF of page 0xE000_E000 select the timer instead of the system registers. sel_tick[1] is asserted when SEC_EN=1 and req_secure=1, and sel_tick[0] in every other case.
- R4: Page 0xE000_5000 asserts sel_ras when RAS_EN=1. When RAS_EN=0 it is handled as unclaimed space.
- R5: Unclaimed space asserts no select. A privileged request (req_user=0) gets rdata 0 with err 0, and writes have no effect. An unprivileged request gets rdata 0 with err 1.
- R6: With SEC_EN=1, a secure request to page 0xE002_E000 is forwarded as the same offset in page 0xE000_E000, using the R2/R3 decode with fwd_secure=0. A timer-range offset therefore selects sel_tick[0].
- R7: With SEC_EN=1, a non-secure request to page 0xE002_E000 asserts no select and gets the R5 local answer.
- R8: With SEC_EN=0, page 0xE002_E000 is handled as unclaimed space (R5) whatever the value of req_secure.
- R9: The cycle after an accepted request, rsp_valid is 1. rsp_rdata and rsp_err then hold the rdata and err of the selected target, as sampled in the request cycle, or the local answer.
- R10: While rst is 1, rsp_valid, rsp_err and rsp_rdata are cleared to 0 at each clock edge.
- R11: fwd_write, fwd_wdata, fwd_user and fwd_size copy the request unchanged. req_size encodes 1, 2, 4 or 8 bytes as 0..3, and every size is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata | input | DATA_W | Write data |
| req_secure | input | 1 | Secure attribute |
| req_user | input | 1 | Unprivileged attribute |
| sel_sys | output | 1 | System-register block select |
| sel_tick | output | 2 | Timer select, [0] non-secure instance, [1] secure instance |
| sel_ras | output | 1 | Error-record block select |
| fwd_off | output | 12 | Offset within the 4 KB target page |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_size | output | 2 | Forwarded size |
| fwd_wdata | output | DATA_W | Forwarded write data |
| fwd_secure | output | 1 | Forwarded secure attribute (cleared through the alias) |
| fwd_user | output | 1 | Forwarded unprivileged attribute |
| sys_rdata | input | DATA_W | System-register block read data |
| sys_err | input | 1 | System-register block error |
| tick_ns_rdata | input | DATA_W | Non-secure timer read data |
| tick_ns_err | input | 1 | Non-secure timer error |
| tick_s_rdata | input | DATA_W | Secure timer read data |
| tick_s_err | input | 1 | Secure timer error |
| ras_rdata | input | DATA_W | Error-record block read data |
| ras_err | input | 1 | Error-record block error |
| rsp_valid | output | 1 | Registered response valid |
| rsp_rdata | output | DATA_W | Registered response data |
| rsp_err | output | 1 | Registered bus error |

## Verification
Every one of the 256 pages of the window is swept at the same set of offsets. The set includes the edges of the timer range (0x00F/0x010 and 0x0EF/0x0F0), so any shift in the override boundary shows up. Each address is tried with all four combinations of the secure and user attributes. This separates the timer banks, shows the alias forwarding versus its local answer, and separates the privileged zero reads from user faults. The same stimulus drives one build with both options and one build with neither, so the alias and error-record pages are checked both as targets and as default space. Stub targets tag their data with their identity, the forwarded secure bit and the offset, and they raise errors on some offsets, so the registered response shows which target was muxed through and whether its error flag was carried. Addresses outside the window and idle cycles inside it confirm that nothing is selected or answered.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

    localparam int ADDR_W = 32;
    localparam int PAGE_W = 8;
    localparam int OFF_W  = 12;

    localparam logic [ADDR_W-PAGE_W-OFF_W-1:0] WIN_TAG = 12'hE00;

    localparam logic [PAGE_W-1:0] PG_SCS   = 8'h0E;
    localparam logic [PAGE_W-1:0] PG_ALIAS = 8'h2E;
    localparam logic [PAGE_W-1:0] PG_RAS   = 8'h05;

    localparam logic [OFF_W-1:0] TICK_LO = 12'h010;
    localparam logic [OFF_W-1:0] TICK_HI = 12'h0EF;

    typedef enum logic [2:0] {
        RT_NONE,
        RT_DEFAULT,
        RT_ALIAS_RAZ,
        RT_SYS,
        RT_TICK_NS,
        RT_TICK_S,
        RT_RAS
    } route_e;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
        logic              secure;
    } dec_in_t;

    typedef struct packed {
        route_e route;
        logic   secure;
    } dec_out_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:PAGE_W+OFF_W] == WIN_TAG;
    endfunction

    function automatic logic in_tick(input logic [OFF_W-1:0] off);
        return (off >= TICK_LO) && (off <= TICK_HI);
    endfunction

    function automatic logic is_local(input route_e r);
        return (r == RT_DEFAULT) || (r == RT_ALIAS_RAZ);
    endfunction

endpackage

// File: rtl/ppb_decode.sv
module ppb_decode
    import ppb_pkg::*;
#(
    parameter bit SEC_EN = 1'b1,
    parameter bit RAS_EN = 1'b1
) (
    input  dec_in_t  din,
    output dec_out_t dout
);

    logic scs_hit;
    logic alias_hit;
    logic ras_hit;
    logic tick_hit;

    assign scs_hit   = din.page == PG_SCS;
    assign alias_hit = SEC_EN && (din.page == PG_ALIAS);
    assign ras_hit   = RAS_EN && (din.page == PG_RAS);
    assign tick_hit  = in_tick(din.off);

    // Priority: timer over system registers over error records over default.
    always_comb begin
        dout.route  = RT_DEFAULT;
        dout.secure = din.secure;
        if (alias_hit) begin
            if (din.secure) begin
                dout.secure = 1'b0;
                dout.route  = tick_hit ? RT_TICK_NS : RT_SYS;
            end else begin
                dout.route = RT_ALIAS_RAZ;
            end
        end else if (scs_hit) begin
            if (tick_hit) begin
                dout.route = (SEC_EN && din.secure) ? RT_TICK_S : RT_TICK_NS;
            end else begin
                dout.route = RT_SYS;
            end
        end else if (ras_hit) begin
            dout.route = RT_RAS;
        end
    end

endmodule

// File: rtl/ppb_resp_mux.sv
module ppb_resp_mux
    import ppb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  route_e                 route,
    input  logic                   user,
    input  logic [DATA_W-1:0]      sys_rdata,
    input  logic                   sys_err,
    input  logic [1:0][DATA_W-1:0] tick_rdata,
    input  logic [1:0]             tick_err,
    input  logic [DATA_W-1:0]      ras_rdata,
    input  logic                   ras_err,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   rsp_err
);

    logic [DATA_W-1:0] nxt_rdata;
    logic              nxt_err;

    always_comb begin
        nxt_rdata = '0;
        nxt_err   = 1'b0;
        unique case (route)
            RT_SYS: begin
                nxt_rdata = sys_rdata;
                nxt_err   = sys_err;
            end
            RT_TICK_NS: begin
                nxt_rdata = tick_rdata[0];
                nxt_err   = tick_err[0];
            end
            RT_TICK_S: begin
                nxt_rdata = tick_rdata[1];
                nxt_err   = tick_err[1];
            end
            RT_RAS: begin
                nxt_rdata = ras_rdata;
                nxt_err   = ras_err;
            end
            RT_DEFAULT, RT_ALIAS_RAZ: begin
                nxt_err = user;
            end
            default: begin
                nxt_rdata = '0;
                nxt_err   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= route != RT_NONE;
            rsp_rdata <= nxt_rdata;
            rsp_err   <= nxt_err;
        end
    end

    // R10: reset leaves the response idle
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !rsp_err && rsp_rdata == '0));

    // R5: local answers always read as zero
    a_r5_local_zero: assert property (@(posedge clk) disable iff (rst)
        is_local(route) |=> (rsp_valid && rsp_rdata == '0));

endmodule

// File: rtl/ppb_router.sv
module ppb_router
    import ppb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter bit SEC_EN = 1'b1,
    parameter bit RAS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_secure,
    input  logic              req_user,
    output logic              sel_sys,
    output logic [1:0]        sel_tick,
    output logic              sel_ras,
    output logic [11:0]       fwd_off,
    output logic              fwd_write,
    output logic [1:0]        fwd_size,
    output logic [DATA_W-1:0] fwd_wdata,
    output logic              fwd_secure,
    output logic              fwd_user,
    input  logic [DATA_W-1:0] sys_rdata,
    input  logic              sys_err,
    input  logic [DATA_W-1:0] tick_ns_rdata,
    input  logic              tick_ns_err,
    input  logic [DATA_W-1:0] tick_s_rdata,
    input  logic              tick_s_err,
    input  logic [DATA_W-1:0] ras_rdata,
    input  logic              ras_err,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);

    localparam int NUM_BANKS = 2;

    logic     in_win;
    dec_in_t  din;
    dec_out_t dout;
    route_e   route;

    assign in_win = in_window(req_addr);
    assign din    = '{page: req_addr[19:12], off: req_addr[11:0], secure: req_secure};

    ppb_decode #(
        .SEC_EN(SEC_EN),
        .RAS_EN(RAS_EN)
    ) u_decode (
        .din (din),
        .dout(dout)
    );

    assign route = (req_valid && in_win) ? dout.route : RT_NONE;

    assign sel_sys = route == RT_SYS;
    assign sel_ras = route == RT_RAS;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign sel_tick[b] = route == ((b == 0) ? RT_TICK_NS : RT_TICK_S);
    end

    assign fwd_off    = req_addr[11:0];
    assign fwd_write  = req_write;
    assign fwd_size   = req_size;
    assign fwd_wdata  = req_wdata;
    assign fwd_secure = dout.secure;
    assign fwd_user   = req_user;

    ppb_resp_mux #(
        .DATA_W(DATA_W)
    ) u_resp (
        .clk       (clk),
        .rst       (rst),
        .route     (route),
        .user      (req_user),
        .sys_rdata (sys_rdata),
        .sys_err   (sys_err),
        .tick_rdata({tick_s_rdata, tick_ns_rdata}),
        .tick_err  ({tick_s_err, tick_ns_err}),
        .ras_rdata (ras_rdata),
        .ras_err   (ras_err),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    // R1: nothing outside the window or without valid is answered
    a_r1_outside_silent: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && in_win) |=> !rsp_valid);

    // R9: accepted requests are answered in the next cycle
    a_r9_rsp_next: assert property (@(posedge clk) disable iff (rst)
        (req_valid && in_win) |=> rsp_valid);

    // R2: at most one target selected
    a_r2_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_ras, sel_tick, sel_sys}));

    // R6: accesses through the alias reach targets as non-secure
    a_r6_alias_clears_secure: assert property (@(posedge clk) disable iff (rst)
        (req_addr[19:12] == PG_ALIAS && (sel_sys || sel_tick != 2'b00)) |-> !fwd_secure);

    // R3: secure timer bank only for secure requests
    a_r3_bank_secure: assert property (@(posedge clk) disable iff (rst)
        sel_tick[1] |-> (req_secure && fwd_secure));

    // R5/R7: an unprivileged request with no target faults
    a_r7_user_fault: assert property (@(posedge clk) disable iff (rst)
        (req_valid && in_win && req_user && !sel_sys && !sel_ras && sel_tick == 2'b00)
        |=> rsp_err);

endmodule

// File: tb/test_ppb_router.sv
`timescale 1ns/1ps
module test_ppb_router;

    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [31:0]   req_addr = '0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_secure = 1'b0;
    logic          req_user = 1'b0;

    logic          sel_sys   [2];
    logic [1:0]    sel_tick  [2];
    logic          sel_ras   [2];
    logic [11:0]   fwd_off   [2];
    logic          fwd_write [2];
    logic [1:0]    fwd_size  [2];
    logic [DW-1:0] fwd_wdata [2];
    logic          fwd_secure[2];
    logic          fwd_user  [2];
    logic [DW-1:0] sys_rd    [2];
    logic [DW-1:0] tns_rd    [2];
    logic [DW-1:0] ts_rd     [2];
    logic [DW-1:0] ras_rd    [2];
    logic          stub_err  [2];
    logic          rsp_valid [2];
    logic [DW-1:0] rsp_rdata [2];
    logic          rsp_err   [2];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic logic [DW-1:0] stub(input logic [7:0] tag, input logic sec,
                                           input logic [11:0] off);
        return {tag, 7'd0, sec, 4'd0, off};
    endfunction

    for (genvar k = 0; k < 2; k++) begin : g_stub
        assign sys_rd[k]   = stub(8'hA1, fwd_secure[k], fwd_off[k]);
        assign tns_rd[k]   = stub(8'hB0, fwd_secure[k], fwd_off[k]);
        assign ts_rd[k]    = stub(8'hB1, fwd_secure[k], fwd_off[k]);
        assign ras_rd[k]   = stub(8'hC5, fwd_secure[k], fwd_off[k]);
        assign stub_err[k] = fwd_off[k][3:0] == 4'hC;
    end

    ppb_router #(.DATA_W(DW), .SEC_EN(1'b1), .RAS_EN(1'b1)) i_ppb_router (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
        .req_secure(req_secure), .req_user(req_user),
        .sel_sys(sel_sys[0]), .sel_tick(sel_tick[0]), .sel_ras(sel_ras[0]),
        .fwd_off(fwd_off[0]), .fwd_write(fwd_write[0]), .fwd_size(fwd_size[0]),
        .fwd_wdata(fwd_wdata[0]), .fwd_secure(fwd_secure[0]), .fwd_user(fwd_user[0]),
        .sys_rdata(sys_rd[0]), .sys_err(stub_err[0]),
        .tick_ns_rdata(tns_rd[0]), .tick_ns_err(stub_err[0]),
        .tick_s_rdata(ts_rd[0]), .tick_s_err(stub_err[0]),
        .ras_rdata(ras_rd[0]), .ras_err(stub_err[0]),
        .rsp_valid(rsp_valid[0]), .rsp_rdata(rsp_rdata[0]), .rsp_err(rsp_err[0])
    );

    ppb_router #(.DATA_W(DW), .SEC_EN(1'b0), .RAS_EN(1'b0)) i_ppb_router_base (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
        .req_secure(req_secure), .req_user(req_user),
        .sel_sys(sel_sys[1]), .sel_tick(sel_tick[1]), .sel_ras(sel_ras[1]),
        .fwd_off(fwd_off[1]), .fwd_write(fwd_write[1]), .fwd_size(fwd_size[1]),
        .fwd_wdata(fwd_wdata[1]), .fwd_secure(fwd_secure[1]), .fwd_user(fwd_user[1]),
        .sys_rdata(sys_rd[1]), .sys_err(stub_err[1]),
        .tick_ns_rdata(tns_rd[1]), .tick_ns_err(stub_err[1]),
        .tick_s_rdata(ts_rd[1]), .tick_s_err(stub_err[1]),
        .ras_rdata(ras_rd[1]), .ras_err(stub_err[1]),
        .rsp_valid(rsp_valid[1]), .rsp_rdata(rsp_rdata[1]), .rsp_err(rsp_err[1])
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h addr=%h", tag, what, act, exp, req_addr);
        end
    endtask

    // 0 none, 1 local, 2 sys, 3 timer ns, 4 timer s, 5 error records
    function automatic int exp_route(input bit sec_en, input bit ras_en, input bit v,
                                     input logic [31:0] a, input bit s);
        logic [7:0]  pg;
        logic [11:0] off;
        bit          tk;
        pg  = a[19:12];
        off = a[11:0];
        tk  = (off >= 12'h010) && (off <= 12'h0EF);
        if (!v || a[31:20] != 12'hE00) return 0;
        if (sec_en && pg == 8'h2E) return s ? (tk ? 3 : 2) : 1;
        if (pg == 8'h0E) return tk ? ((sec_en && s) ? 4 : 3) : 2;
        if (ras_en && pg == 8'h05) return 5;
        return 1;
    endfunction

    function automatic string rtag(input bit sec_en, input logic [31:0] a, input bit s,
                                   input int er);
        if (er == 0) return "R1";
        if (a[19:12] == 8'h2E) return sec_en ? (s ? "R6" : "R7") : "R8";
        if (a[19:12] == 8'h05) return "R4";
        if (er == 3 || er == 4) return "R3";
        if (er == 2) return "R2";
        return "R5";
    endfunction

    task automatic txn(input logic [31:0] a, input bit v, input bit s, input bit u,
                       input bit w, input logic [1:0] sz);
        int            er   [2];
        logic [DW-1:0] edata[2];
        logic          eerr [2];
        string         tg   [2];
        req_valid  = v;
        req_addr   = a;
        req_secure = s;
        req_user   = u;
        req_write  = w;
        req_size   = sz;
        req_wdata  = {a[15:0], ~a[15:0]};
        #1;
        for (int k = 0; k < 2; k++) begin
            logic [3:0] esel;
            logic       esec;
            logic [7:0] tag;
            er[k] = exp_route(k == 0, k == 0, v, a, s);
            tg[k] = rtag(k == 0, a, s, er[k]);
            esel  = (er[k] >= 2) ? (4'b0001 << (er[k] - 2)) : 4'b0000;
            esec  = (k == 0 && a[19:12] == 8'h2E) ? 1'b0 : s;
            chk({sel_ras[k], sel_tick[k], sel_sys[k]} == esel, tg[k], "select",
                {60'd0, sel_ras[k], sel_tick[k], sel_sys[k]}, {60'd0, esel});
            if (er[k] >= 2) begin
                chk(fwd_secure[k] == esec, tg[k], "fwd_secure", 64'(fwd_secure[k]), 64'(esec));
                chk(fwd_off[k] == a[11:0], tg[k], "fwd_off", 64'(fwd_off[k]), 64'(a[11:0]));
            end
            chk({fwd_write[k], fwd_size[k], fwd_user[k], fwd_wdata[k]} ==
                {w, sz, u, req_wdata}, "R11", "passthrough",
                {28'd0, fwd_write[k], fwd_size[k], fwd_user[k], fwd_wdata[k]},
                {28'd0, w, sz, u, req_wdata});
            case (er[k])
                2:       tag = 8'hA1;
                3:       tag = 8'hB0;
                4:       tag = 8'hB1;
                default: tag = 8'hC5;
            endcase
            if (er[k] >= 2) begin
                edata[k] = stub(tag, esec, a[11:0]);
                eerr[k]  = a[3:0] == 4'hC;
            end else begin
                edata[k] = '0;
                eerr[k]  = u;
            end
        end
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(rsp_valid[k] == (er[k] != 0), "R9", {tg[k], " rsp_valid"},
                64'(rsp_valid[k]), 64'(er[k] != 0));
            if (er[k] != 0) begin
                chk(rsp_rdata[k] == edata[k], "R9", {tg[k], " rsp_rdata"},
                    64'(rsp_rdata[k]), 64'(edata[k]));
                chk(rsp_err[k] == eerr[k], "R9", {tg[k], " rsp_err"},
                    64'(rsp_err[k]), 64'(eerr[k]));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] offs [8];
        offs = '{12'h000, 12'h00C, 12'h00F, 12'h010, 12'h0EF, 12'h0F0, 12'h10C, 12'hFFC};
        repeat (3) @(negedge clk);
        // R10: reset state
        for (int k = 0; k < 2; k++) begin
            chk({rsp_valid[k], rsp_err[k]} == 2'b00 && rsp_rdata[k] == '0, "R10",
                "reset response", {31'd0, rsp_valid[k], rsp_err[k], rsp_rdata[k]}, 64'd0);
        end
        rst = 1'b0;
        // R1: idle inside the window, requests outside it
        txn(32'hE000_E010, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2);
        txn(32'hE000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0);
        txn(32'hE010_0000, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2);
        txn(32'hDFFF_FFFC, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2);
        txn(32'h2000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1);
        txn(32'hE02E_E010, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3);
        // Sweep of all pages, boundary offsets and attribute pairs
        for (int p = 0; p < 256; p++) begin
            for (int o = 0; o < 8; o++) begin
                for (int at = 0; at < 4; at++) begin
                    txn({12'hE00, 8'(p), offs[o]}, 1'b1, at[1], at[0], o[0], 2'(o + at));
                end
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule